// File: doc/BRIEF.md
# Class-Partitioned Virtual Channel Allocator

This block hands out output virtual channels at the next router to packets whose head flits wait in this router's input virtual channels. Each of the `NUM_PORTS` ports carries eight virtual channels. A channel index encodes its purpose. Bit 2 is the message class (0 = request, 1 = reply). Bit 1 is the resource class (0 = minimal, 1 = non-minimal). Bit 0 picks one of the two channels inside that class pair. The global output VC number is `port*8 + index`.

Legal requests are pruned before arbitration. An input VC only looks at channels of its own message class on its routed port. It also only looks at the two channels of the resource class it asks for, and a minimal-class input VC may not ask for a non-minimal channel. This keeps the first-stage arbiters four wide and the second-stage arbiters at most `NUM_PORTS*4` wide, instead of spanning every channel of the router.

Matching is separable and input-first, and it finishes in one combinational pass. Each input VC uses a round-robin arbiter to pick one free legal candidate. Each output VC then uses a round-robin arbiter to pick one of the input VCs that chose it. A granted output VC stays owned until the caller pulses its release line when the packet's tail leaves. A caller-supplied busy vector also blocks channels.

Top module: `sparse_vc_alloc`

## Requirements
- R1: After reset no output VC is owned, and with no head flit valid every grant bit is 0.
- R2: A grant to an input VC names a channel on that input VC's routed port whose message class (index bit 2) equals the input VC's own bit 2.
- R3: The granted channel's resource class (bit 1) equals the requested class. A minimal-class input VC (own bit 1 = 0) asking for the non-minimal class (request = 1) receives no grant.
- R4: An output VC that has its busy input high, or that is owned, is never granted.
- R5: Each input VC receives at most one grant bit per cycle, and each output VC is granted to at most one input VC per cycle.
- R6: An output VC becomes owned at the clock edge that ends its grant cycle. It stops being owned at the edge ending a cycle with its release input high. A release of a channel that is not owned has no effect.
- R7: An input VC without a valid head flit receives no grant.
- R8: If any valid, legal request has at least one free candidate, at least one grant is made that cycle.
- R9: An input VC's candidate order is round-robin over index bits [1:0]. After reset the lowest legal candidate wins. After a grant, the next priority starts just past the granted candidate.
- R10: Input VCs contending for one output VC are served round-robin. From reset the lowest-numbered contender wins, and successive allocations alternate between two persistent contenders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_vld_i | input | NUM_PORTS*8 | Head flit waiting, one bit per input VC |
| route_port_i | input | NUM_PORTS*8*PW | Routed output port per input VC, PW bits each |
| req_rc_i | input | NUM_PORTS*8 | Requested resource class per input VC (1 = non-minimal) |
| ovc_busy_i | input | NUM_PORTS*8 | Output VC unavailable, per global output VC |
| ovc_rel_i | input | NUM_PORTS*8 | Tail released, frees the output VC |
| vc_gnt_o | output | NUM_PORTS*8*8 | One-hot grant per input VC, bit = channel index on the routed port |
| ovc_owned_o | output | NUM_PORTS*8 | Ownership state per global output VC |

## Verification
The hardest situation to reach from the ports is the one where the round-robin state decides the result. Several input VCs have to target the same single free channel while every other legal candidate is masked, and this has to happen over several allocation rounds. Directed sequences create it. They hold the busy vector high on all but one channel of a port, release the owned channel between rounds, and watch which contender wins each round. Long constrained-random runs exercise the rest. Those runs mix random routes, class requests, busy masks and releases, and they check the class rules, exclusivity, progress and the ownership record against a model kept in the bench.

// File: rtl/svca_pkg.sv
package svca_pkg;
   localparam int VCS      = 8;   // channels per port, fixed by the class partition
   localparam int CAND     = 4;   // legal candidates per port for one message class
   localparam int MSG_BIT  = 2;
   localparam int RC_BIT   = 1;
endpackage

// File: rtl/svca_rr_arb.sv
module svca_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic         adv_i,
   output logic [N-1:0] gnt_o
);
   localparam int IW = (N > 1) ? $clog2(N) : 1;

   generate
      if (N < 1) begin : g_bad_n
         $error("svca_rr_arb: N must be at least 1");
      end
   endgenerate

   logic [IW-1:0] ptr_q;
   logic [IW-1:0] win_idx;
   logic          found;

   always_comb begin
      gnt_o   = '0;
      win_idx = '0;
      found   = 1'b0;
      for (int off = 0; off < N; off++) begin
         int idx;
         idx = (int'(ptr_q) + off) % N;
         if (!found && req_i[idx]) begin
            found      = 1'b1;
            gnt_o[idx] = 1'b1;
            win_idx    = IW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (adv_i && found)
         ptr_q <= IW'((int'(win_idx) + 1) % N);
   end

   // R5
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_o));
   // R5
   gnt_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_o & ~req_i) == '0);
endmodule

// File: rtl/svca_in_sel.sv
module svca_in_sel
   import svca_pkg::*;
#(
   parameter int NP      = 5,
   parameter int PW      = 3,
   parameter int IVC_IDX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               head_i,
   input  logic [PW-1:0]      route_i,
   input  logic               req_rc_i,
   input  logic [NP*VCS-1:0]  free_i,
   input  logic               win_i,
   output logic [CAND-1:0]    pick_o
);
   localparam int MSG = (IVC_IDX >> MSG_BIT) & 1;
   localparam int IRC = (IVC_IDX >> RC_BIT) & 1;

   logic [CAND-1:0] leg;
   logic [CAND-1:0] cand;

   always_comb begin
      for (int j = 0; j < CAND; j++)
         leg[j] = head_i && ((j >> 1) == int'(req_rc_i)) && (IRC == 1 || !req_rc_i);
      cand = '0;
      for (int p = 0; p < NP; p++)
         if (route_i == PW'(p))
            for (int j = 0; j < CAND; j++)
               cand[j] = free_i[p*VCS + MSG*CAND + j];
      cand = cand & leg;
   end

   svca_rr_arb #(.N(CAND)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (cand),
      .adv_i (win_i),
      .gnt_o (pick_o)
   );

   // R7
   pick_needs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !head_i |-> (pick_o == '0));
   // R3
   min_no_nonmin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (IRC == 0 && req_rc_i) |-> (pick_o == '0));
endmodule

// File: rtl/svca_own.sv
module svca_own #(
   parameter int N = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] rel_i,
   input  logic [N-1:0] busy_i,
   output logic [N-1:0] owned_o,
   output logic [N-1:0] free_o
);
   logic [N-1:0] owned_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         owned_q <= '0;
      else
         owned_q <= (owned_q & ~rel_i) | set_i;
   end

   assign owned_o = owned_q;
   assign free_o  = ~busy_i & ~owned_q;

   // R4
   no_grant_unavail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i & (busy_i | owned_q)) == '0);

   genvar o;
   generate
      for (o = 0; o < N; o++) begin : g_chk
         // R6
         own_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[o] |=> owned_q[o]);
         // R6
         own_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_i[o] && !set_i[o]) |=> !owned_q[o]);
      end
   endgenerate
endmodule

// File: rtl/sparse_vc_alloc.sv
module sparse_vc_alloc
   import svca_pkg::*;
#(
   parameter int NUM_PORTS = 5,
   localparam int PW   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int NIVC = NUM_PORTS * VCS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NIVC-1:0]      head_vld_i,
   input  logic [NIVC*PW-1:0]   route_port_i,
   input  logic [NIVC-1:0]      req_rc_i,
   input  logic [NIVC-1:0]      ovc_busy_i,
   input  logic [NIVC-1:0]      ovc_rel_i,
   output logic [NIVC*VCS-1:0]  vc_gnt_o,
   output logic [NIVC-1:0]      ovc_owned_o
);
   localparam int OW = NUM_PORTS * CAND;   // contenders per output VC

   generate
      if (NUM_PORTS < 2) begin : g_bad_ports
         $error("sparse_vc_alloc: NUM_PORTS must be at least 2");
      end
   endgenerate

   logic [NIVC*CAND-1:0] pick;
   logic [NIVC*OW-1:0]   og;
   logic [NIVC-1:0]      ovc_set;
   logic [NIVC-1:0]      ivc_win;
   logic [NIVC-1:0]      free;

   svca_own #(.N(NIVC)) u_own (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (ovc_set),
      .rel_i   (ovc_rel_i),
      .busy_i  (ovc_busy_i),
      .owned_o (ovc_owned_o),
      .free_o  (free)
   );

   genvar i, o;
   generate
      for (i = 0; i < NIVC; i++) begin : g_in
         svca_in_sel #(.NP(NUM_PORTS), .PW(PW), .IVC_IDX(i % VCS)) u_sel (
            .clk      (clk),
            .rst_n    (rst_n),
            .head_i   (head_vld_i[i]),
            .route_i  (route_port_i[i*PW +: PW]),
            .req_rc_i (req_rc_i[i]),
            .free_i   (free),
            .win_i    (ivc_win[i]),
            .pick_o   (pick[i*CAND +: CAND])
         );
         assign ivc_win[i] = |vc_gnt_o[i*VCS +: VCS];
      end

      for (o = 0; o < NIVC; o++) begin : g_out
         localparam int OP = o / VCS;
         localparam int OM = (o / CAND) % 2;
         localparam int OJ = o % CAND;
         logic [OW-1:0] oreq;

         always_comb begin
            for (int q = 0; q < NUM_PORTS; q++)
               for (int t = 0; t < CAND; t++) begin
                  int iv;
                  iv = q*VCS + OM*CAND + t;
                  oreq[q*CAND + t] = pick[iv*CAND + OJ] &&
                                     (route_port_i[iv*PW +: PW] == PW'(OP));
               end
         end

         svca_rr_arb #(.N(OW)) u_oarb (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (oreq),
            .adv_i (1'b1),
            .gnt_o (og[o*OW +: OW])
         );
         assign ovc_set[o] = |og[o*OW +: OW];
      end
   endgenerate

   always_comb begin
      vc_gnt_o = '0;
      for (int ov = 0; ov < NIVC; ov++)
         for (int q = 0; q < NUM_PORTS; q++)
            for (int t = 0; t < CAND; t++)
               if (og[ov*OW + q*CAND + t])
                  vc_gnt_o[(q*VCS + ((ov/CAND)%2)*CAND + t)*VCS + (ov % VCS)] = 1'b1;
   end

   generate
      for (i = 0; i < NIVC; i++) begin : g_gchk
         // R5
         ivc_one_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(vc_gnt_o[i*VCS +: VCS]));
         // R7
         no_head_no_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !head_vld_i[i] |-> (vc_gnt_o[i*VCS +: VCS] == '0));
      end
   endgenerate
endmodule

// File: tb/sim_sparse_vc_alloc.sv
`timescale 1ns/1ps
module sim_sparse_vc_alloc;
   localparam int NP   = 5;
   localparam int PW   = 3;
   localparam int NIVC = NP * 8;

   logic                clk = 1'b0;
   logic                rst_n;
   logic [NIVC-1:0]     head, req_rc, busy, rel;
   logic [NIVC*PW-1:0]  route;
   logic [NIVC*8-1:0]   gnt;
   logic [NIVC-1:0]     owned;
   logic [NIVC-1:0]     owned_m;
   logic [NIVC-1:0]     set_snap;
   int                  n_chk = 0;
   int                  n_fail = 0;
   bit                  done = 0;

   always #5 clk = ~clk;

   sparse_vc_alloc #(.NUM_PORTS(NP)) u0 (
      .clk(clk), .rst_n(rst_n), .head_vld_i(head), .route_port_i(route),
      .req_rc_i(req_rc), .ovc_busy_i(busy), .ovc_rel_i(rel),
      .vc_gnt_o(gnt), .ovc_owned_o(owned)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int gpos(input int iv);
      for (int b = 0; b < 8; b++) if (gnt[iv*8 + b]) return b;
      return -1;
   endfunction

   function automatic int rport(input int iv);
      return int'(route[iv*PW +: PW]);
   endfunction

   function automatic bit legal(input int iv);
      return head[iv] && (((iv >> 1) & 1) == 1 || !req_rc[iv]);
   endfunction

   task automatic clear_inputs();
      head = '0; req_rc = '0; busy = '0; rel = '0; route = '0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      clear_inputs();
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      owned_m = '0;
   endtask

   // grant checks, then model update at the edge, then ownership check
   task automatic step();
      int owners [NIVC];
      bit any_gnt, can_go;
      int bad5, bad2, bad3, bad4, bad7;
      #2;
      for (int o = 0; o < NIVC; o++) owners[o] = 0;
      set_snap = '0; any_gnt = 0; can_go = 0;
      bad5 = 0; bad2 = 0; bad3 = 0; bad4 = 0; bad7 = 0;
      for (int iv = 0; iv < NIVC; iv++) begin
         int c, v, ov;
         c = $countones(gnt[iv*8 +: 8]);
         if (c > 1) bad5++;
         if (!head[iv] && c != 0) bad7++;
         if (legal(iv))
            for (int k = 0; k < 2; k++) begin
               ov = rport(iv)*8 + ((iv>>2)&1)*4 + int'(req_rc[iv])*2 + k;
               if (!busy[ov] && !owned_m[ov]) can_go = 1;
            end
         v = gpos(iv);
         if (v >= 0) begin
            any_gnt = 1;
            ov = rport(iv)*8 + v;
            if (((v>>2)&1) != ((iv>>2)&1)) bad2++;
            if (((v>>1)&1) != int'(req_rc[iv]) || !legal(iv)) bad3++;
            if (busy[ov] || owned_m[ov]) bad4++;
            owners[ov]++;
            set_snap[ov] = 1'b1;
         end
      end
      for (int o = 0; o < NIVC; o++) if (owners[o] > 1) bad5++;
      check(bad2 == 0, "R2 message class/port of grant", bad2, 0);
      check(bad3 == 0, "R3 resource class of grant", bad3, 0);
      check(bad4 == 0, "R4 busy or owned channel granted", bad4, 0);
      check(bad5 == 0, "R5 exclusivity", bad5, 0);
      check(bad7 == 0, "R7 grant without head", bad7, 0);
      check(!can_go || any_gnt, "R8 progress", any_gnt, 1);
      @(posedge clk);
      owned_m = (owned_m & ~rel) | set_snap;
      @(negedge clk);
      check(owned == owned_m, "R6 ownership record", owned, owned_m);
   endtask

   task automatic set_req(input int iv, input int port, input bit rc);
      head[iv] = 1'b1;
      route[iv*PW +: PW] = PW'(port);
      req_rc[iv] = rc;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      rst_n = 1'b0;
      clear_inputs();
      owned_m = '0;
      do_reset();

      // R1: reset state, idle inputs
      #2;
      check(owned == '0, "R1 owned after reset", owned, 0);
      check(gnt == '0, "R1 idle grants", 0, 0);
      step();

      // R9: ivc 9 (minimal, req class 0) to port 3, lowest candidate first, then the next
      do_reset();
      set_req(9, 3, 1'b0);
      #2; check(gpos(9) == 0, "R9 first candidate", gpos(9), 0);
      step();
      head[9] = 1'b0; rel[24] = 1'b1;
      step();
      rel = '0; head[9] = 1'b1;
      #2; check(gpos(9) == 1, "R9 rotated candidate", gpos(9), 1);
      step();

      // R3: minimal ivc asking non-minimal gets nothing; others get proper class
      do_reset();
      set_req(8, 0, 1'b1);
      set_req(10, 0, 1'b1);
      set_req(14, 0, 1'b0);
      #2;
      check(gpos(8) == -1, "R3 minimal asking non-minimal", gpos(8), -1);
      check(gpos(10) == 2, "R3 non-minimal request", gpos(10), 2);
      check(gpos(14) == 4, "R3 reply class minimal", gpos(14), 4);
      step();

      // R4: busy masking
      do_reset();
      busy[2*8 +: 8] = 8'h7F;
      set_req(15, 2, 1'b1);
      #2; check(gpos(15) == 7, "R4 skip busy channel", gpos(15), 7);
      @(negedge clk);
      busy[2*8 + 7] = 1'b1;
      #2; check(gpos(15) == -1, "R4 all candidates busy", gpos(15), -1);
      @(negedge clk);

      // R10: two contenders, one free channel, alternating winners
      do_reset();
      busy[2*8 +: 8] = 8'hFE;
      for (int r = 0; r < 4; r++) begin
         int exp_w, other;
         exp_w = (r % 2 == 0) ? 0 : 8;
         other = (r % 2 == 0) ? 8 : 0;
         set_req(0, 2, 1'b0);
         set_req(8, 2, 1'b0);
         #2;
         check(gpos(exp_w) == 0 && gpos(other) == -1, "R10 round-robin winner",
               gpos(exp_w), 0);
         step();
         head[0] = 1'b0; head[8] = 1'b0; rel[16] = 1'b1;
         step();
         rel = '0;
      end

      // random phase
      do_reset();
      for (int cyc = 0; cyc < 3000; cyc++) begin
         for (int iv = 0; iv < NIVC; iv++) begin
            head[iv]   = ($urandom % 2) == 0;
            req_rc[iv] = ($urandom % 2) == 0;
            route[iv*PW +: PW] = PW'($urandom % NP);
         end
         for (int o = 0; o < NIVC; o++) begin
            busy[o] = ($urandom % 5) == 0;
            rel[o]  = owned_m[o] ? (($urandom % 3) == 0) : (($urandom % 20) == 0);
         end
         step();
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule